// File: doc/BRIEF.md
# Memory-Mapped GPIO Port

A general-purpose I/O port that a host processor drives through four word-wide registers on a simple bus. The bus has one write strobe and a combinational read path. The port drives an output-value vector and an output-enable vector for tri-state pads. It also samples the input pins through a two-stage synchronizer. The number of pins equals the register width: 8, 16, 32 or 64.

There are two ways to drive the outputs, chosen when the block is built. In set/clear mode, software can load the whole output latch at once, or it can raise or lower selected bits atomically with no read-modify-write. In set-only mode, a single output register holds the full output value and reads back what is being driven, and the level register can only be read. The following are also fixed at build time:
- the polarity of the direction register;
- an optional mirroring of pin numbering;
- an optional byte swap of the bus word;
- an option to return the latch value, rather than the sampled pin, for pins that are outputs.

Top module: `gpio_mmio_port`

## Requirements
- R1: While and after reset, pinOut and pinOe are all zeros, so every pin is an input. The direction register reads all zeros when a 1 means output, and all ones when a 1 means input.
- R2: In set/clear mode, a write to word address 0 loads the whole output latch, and pinOut shows it one cycle after the strobe. In any cycle with busWr low, pinOut and pinOe hold their value.
- R3: In set/clear mode, a write to address 1 drives high every pin whose mapped written bit is 1, and leaves the other pins unchanged.
- R4: In set/clear mode, a write to address 2 drives low every pin whose mapped written bit is 1, and leaves the other pins unchanged.
- R5: In set-only mode, a write to address 1 loads the full output latch, and a read of address 1 returns the latch. Writes to address 0 or 2 leave pinOut unchanged, and a read of address 2 returns zero.
- R6: A write to address 3 loads the direction register. With output polarity, pinOe equals the register. With input polarity, pinOe is its inverse.
- R7: With mirroring enabled, pin n corresponds to register bit W-1-n in every register. Without it, pin n is register bit n.
- R8: With byte swap enabled, bus byte k carries register byte W/8-1-k. Swap has no effect at width 8. Byte swap combined with width 64, or any width other than 8, 16, 32 or 64, is an invalid build.
- R9: A read of address 0 returns pin levels after two flops. A pinIn value that is stable before clock edge e appears on the read after edge e+1, and not after edge e.
- R10: With the read-output option, a read of address 0 returns the latch bit for pins whose pinOe is 1. Without the option, it returns the synchronized pin.
- R11: In set/clear mode, reads of addresses 1 and 2 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 2 | Word address: 0 level/data, 1 set, 2 clear, 3 direction |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| pinIn | input | DATA_W | Pad input levels, asynchronous |
| pinOut | output | DATA_W | Output latch to the pads |
| pinOe | output | DATA_W | Output enable to the pads, 1 drives |

## Verification
The hardest case to reach is a level read in which some pins are outputs and some are inputs. For the two views to be told apart, the latch and the synchronized pin must disagree on exactly the pins that are outputs. The bench builds this case directly. It turns half the pins to outputs while the input pins carry a pattern that differs from the latch. Then it runs random writes, direction changes and pin changes.

Two instances share the stimulus:
- one in set/clear mode with mirroring, byte swap and the read-output option;
- one in set-only mode with input polarity and no lane remapping.

A single write therefore exercises both sides of every build option.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Word addresses on the host bus
  localparam logic [1:0] ADDR_LEVEL = 2'd0;
  localparam logic [1:0] ADDR_SET   = 2'd1;
  localparam logic [1:0] ADDR_CLR   = 2'd2;
  localparam logic [1:0] ADDR_DIR   = 2'd3;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic ldLatch;
    logic orLatch;
    logic andnLatch;
    logic ldDir;
  } gpioStrobes_t;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_LEVEL = 2'd1,
    RD_LATCH = 2'd2,
    RD_DIR   = 2'd3
  } gpioRdSel_t;

endpackage

// File: rtl/gpio_lane_map.sv
// Maps between bus bit order and pin order. The mapping is its own inverse,
// so the same module serves the write and the read path.
module gpio_lane_map #(
  parameter int DATA_W    = 32,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar n = 0; n < DATA_W; n++) begin : gLane
    localparam int REG_BIT = MIRROR ? (DATA_W - 1 - n) : n;
    localparam int BUS_BIT = BYTE_SWAP ? ((NBYTES - 1 - REG_BIT / 8) * 8 + REG_BIT % 8)
                                       : REG_BIT;
    assign dOut[n] = dIn[BUS_BIT];
  end
endmodule

// File: rtl/gpio_ctrl.sv
// Address decode: turns bus strobes into datapath strobes and a read select.
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter bit HAS_CLEAR = 1'b1
) (
  input  logic         busWr,
  input  logic [1:0]   busAddr,
  output gpioStrobes_t strobes,
  output gpioRdSel_t   rdSel
);
  always_comb begin
    strobes = '0;
    if (busWr) begin
      unique case (busAddr)
        ADDR_LEVEL: strobes.ldLatch   = HAS_CLEAR;
        ADDR_SET: begin
          strobes.orLatch = HAS_CLEAR;
          strobes.ldLatch = !HAS_CLEAR;
        end
        ADDR_CLR:   strobes.andnLatch = HAS_CLEAR;
        ADDR_DIR:   strobes.ldDir     = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_LEVEL: rdSel = RD_LEVEL;
      ADDR_SET:   rdSel = HAS_CLEAR ? RD_ZERO : RD_LATCH;
      ADDR_CLR:   rdSel = RD_ZERO;
      ADDR_DIR:   rdSel = RD_DIR;
      default:    rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/gpio_datapath.sv
// Output latch, direction register, input synchronizer and read mux.
// Everything here is in pin order.
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit DIR_IS_INPUT = 1'b0,
  parameter bit READ_OUT     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobes_t      strobes,
  input  gpioRdSel_t        rdSel,
  input  logic [DATA_W-1:0] wrPins,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] rdPins,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);
  localparam logic [DATA_W-1:0] DIR_RESET = {DATA_W{DIR_IS_INPUT}};

  logic [DATA_W-1:0] outLatch;
  logic [DATA_W-1:0] dirReg;
  logic [DATA_W-1:0] syncA;
  logic [DATA_W-1:0] syncB;
  logic [DATA_W-1:0] levelView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      dirReg   <= DIR_RESET;
      syncA    <= '0;
      syncB    <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (strobes.ldLatch)        outLatch <= wrPins;
      else if (strobes.orLatch)   outLatch <= outLatch | wrPins;
      else if (strobes.andnLatch) outLatch <= outLatch & ~wrPins;
      if (strobes.ldDir)          dirReg   <= wrPins;
    end
  end

  if (DIR_IS_INPUT) begin : gDirIn
    assign pinOe = ~dirReg;
  end else begin : gDirOut
    assign pinOe = dirReg;
  end

  if (READ_OUT) begin : gReadOut
    for (genvar n = 0; n < DATA_W; n++) begin : gPin
      assign levelView[n] = pinOe[n] ? outLatch[n] : syncB[n];
    end
  end else begin : gReadPin
    assign levelView = syncB;
  end

  always_comb begin
    unique case (rdSel)
      RD_LEVEL: rdPins = levelView;
      RD_LATCH: rdPins = outLatch;
      RD_DIR:   rdPins = dirReg;
      default:  rdPins = '0;
    endcase
  end

  assign pinOut = outLatch;
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit HAS_CLEAR    = 1'b1,
  parameter bit DIR_IS_INPUT = 1'b0,
  parameter bit MIRROR       = 1'b0,
  parameter bit BYTE_SWAP    = 1'b0,
  parameter bit READ_OUT     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);
  // Build checks (R8)
  if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : gBadWidth
    $error("gpio_mmio_port: DATA_W must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && DATA_W == 64) begin : gBadSwap
    $error("gpio_mmio_port: byte swap is not allowed at 64 bits");
  end

  gpioStrobes_t      strobes;
  gpioRdSel_t        rdSel;
  logic [DATA_W-1:0] wrPins;
  logic [DATA_W-1:0] rdPins;

  gpio_lane_map #(.DATA_W(DATA_W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) wrMapI (
    .dIn(busWrData), .dOut(wrPins)
  );

  gpio_ctrl #(.HAS_CLEAR(HAS_CLEAR)) ctrlI (
    .busWr(busWr), .busAddr(busAddr), .strobes(strobes), .rdSel(rdSel)
  );

  gpio_datapath #(.DATA_W(DATA_W), .DIR_IS_INPUT(DIR_IS_INPUT), .READ_OUT(READ_OUT)) dpI (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel), .wrPins(wrPins),
    .pinIn(pinIn), .rdPins(rdPins), .pinOut(pinOut), .pinOe(pinOe)
  );

  gpio_lane_map #(.DATA_W(DATA_W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) rdMapI (
    .dIn(rdPins), .dOut(busRdData)
  );
endmodule

// File: rtl/gpio_mmio_port_chk.sv
module gpio_mmio_port_chk #(
  parameter int DATA_W       = 32,
  parameter bit HAS_CLEAR    = 1'b1,
  parameter bit DIR_IS_INPUT = 1'b0,
  parameter bit MIRROR       = 1'b0,
  parameter bit BYTE_SWAP    = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [1:0]        busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] pinOut,
  input logic [DATA_W-1:0] pinOe
);
  localparam int NB = DATA_W / 8;

  function automatic logic [DATA_W-1:0] toPins(input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int n = 0; n < DATA_W; n++) begin
      int idx;
      idx = MIRROR ? DATA_W - 1 - n : n;
      if (BYTE_SWAP) idx = (NB - 1 - idx / 8) * 8 + idx % 8;
      r[n] = b[idx];
    end
    return r;
  endfunction

  logic [DATA_W-1:0] wrMapped;
  assign wrMapped = toPins(busWrData);

  always @(negedge clk) begin
    if (!rstN) assert_reset_R1: assert (pinOut == '0 && pinOe == '0);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> ($stable(pinOut) && $stable(pinOe)));

  assert_dir_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == 2'd3) |=> $stable(pinOe));

  if (HAS_CLEAR) begin : gPair
    assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == 2'd0) |=> pinOut == $past(wrMapped));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == 2'd1) |=>
        ((pinOut & $past(wrMapped)) == $past(wrMapped)) &&
        ((pinOut & ~$past(wrMapped)) == ($past(pinOut) & ~$past(wrMapped))));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == 2'd2) |=>
        ((pinOut & $past(wrMapped)) == '0) &&
        ((pinOut & ~$past(wrMapped)) == ($past(pinOut) & ~$past(wrMapped))));

    assert_zero_read_R11: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == 2'd1 || busAddr == 2'd2) |-> busRdData == '0);
  end else begin : gSetOnly
    assert_readback_R5: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == 2'd1) |-> toPins(busRdData) == pinOut);

    assert_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr != 2'd1) |=> $stable(pinOut));
  end
endmodule

bind gpio_mmio_port gpio_mmio_port_chk #(
  .DATA_W(DATA_W), .HAS_CLEAR(HAS_CLEAR), .DIR_IS_INPUT(DIR_IS_INPUT),
  .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)
) chkI (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
  .busRdData(busRdData), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/gpio_mmio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mmio_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [15:0] busWrData = '0;
  logic [15:0] pinIn = '0;
  logic [15:0] rd0, out0, oe0, rd1, out1, oe1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // Instance 0: set/clear, output polarity, mirrored, byte swapped, read-output
  gpio_mmio_port #(.DATA_W(16), .HAS_CLEAR(1'b1), .DIR_IS_INPUT(1'b0), .MIRROR(1'b1),
                   .BYTE_SWAP(1'b1), .READ_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(rd0), .pinIn(pinIn), .pinOut(out0), .pinOe(oe0));

  // Instance 1: set-only, input polarity, plain lanes, pin read
  gpio_mmio_port #(.DATA_W(16), .HAS_CLEAR(1'b0), .DIR_IS_INPUT(1'b1), .MIRROR(1'b0),
                   .BYTE_SWAP(1'b0), .READ_OUT(1'b0)) dut1_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(rd1), .pinIn(pinIn), .pinOut(out1), .pinOe(oe1));

  // ---------------- reference model ----------------
  bit cfgClr [2] = '{1'b1, 1'b0};
  bit cfgDirIn [2] = '{1'b0, 1'b1};
  bit cfgMir [2] = '{1'b1, 1'b0};
  bit cfgSwp [2] = '{1'b1, 1'b0};
  bit cfgRo [2] = '{1'b1, 1'b0};
  logic [15:0] mOut [2];
  logic [15:0] mDir [2];
  logic [15:0] mS1, mS2;

  function automatic logic [15:0] laneMap(input logic [15:0] x, input bit mir, input bit swp);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      int k;
      k = mir ? 15 - n : n;
      if (swp) k = k ^ 8;
      r[n] = x[k];
    end
    return r;
  endfunction

  function automatic logic [15:0] modelOe(input int i);
    return cfgDirIn[i] ? ~mDir[i] : mDir[i];
  endfunction

  function automatic logic [15:0] modelRead(input int i, input logic [1:0] a);
    logic [15:0] lvl, oe;
    oe = modelOe(i);
    for (int n = 0; n < 16; n++) lvl[n] = (cfgRo[i] && oe[n]) ? mOut[i][n] : mS2[n];
    case (a)
      2'd0: return laneMap(lvl, cfgMir[i], cfgSwp[i]);
      2'd1: return cfgClr[i] ? 16'h0 : laneMap(mOut[i], cfgMir[i], cfgSwp[i]);
      2'd3: return laneMap(mDir[i], cfgMir[i], cfgSwp[i]);
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mOut[i] = '0;
      mDir[i] = cfgDirIn[i] ? 16'hFFFF : 16'h0000;
    end
    mS1 = '0;
    mS2 = '0;
  endtask

  task automatic modelStep();
    if (!rstN) begin
      modelReset();
    end else begin
      mS2 = mS1;
      mS1 = pinIn;
      if (busWr) begin
        for (int i = 0; i < 2; i++) begin
          logic [15:0] p;
          p = laneMap(busWrData, cfgMir[i], cfgSwp[i]);
          case (busAddr)
            2'd0: if (cfgClr[i]) mOut[i] = p;
            2'd1: mOut[i] = cfgClr[i] ? (mOut[i] | p) : p;
            2'd2: if (cfgClr[i]) mOut[i] = mOut[i] & ~p;
            default: mDir[i] = p;
          endcase
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rdTag(input logic [1:0] a);
    case (a)
      2'd0: return "R9/R10 level read";
      2'd1: return "R5/R11 set read";
      2'd2: return "R11 clear read";
      default: return "R6 dir read";
    endcase
  endfunction

  // One clock: model updates at the rising edge, outputs compared at the falling edge.
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check("R2/R3/R4 pinOut inst0", out0, mOut[0]);
    check("R5 pinOut inst1", out1, mOut[1]);
    check("R6 pinOe inst0", oe0, modelOe(0));
    check("R6 pinOe inst1", oe1, modelOe(1));
    check({rdTag(busAddr), " inst0"}, rd0, modelRead(0, busAddr));
    check({rdTag(busAddr), " inst1"}, rd1, modelRead(1, busAddr));
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    busWr = 1'b1;
    busAddr = a;
    busWrData = d;
    tick();
    busWr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a);
    busAddr = a;
    #0.5;
  endtask

  initial begin
    modelReset();
    #1 rstN = 1'b0;
    repeat (4) tick();
    check("R1 reset pinOut inst0", out0, 16'h0);
    check("R1 reset pinOe inst0", oe0, 16'h0);
    check("R1 reset pinOe inst1", oe1, 16'h0);
    peek(2'd3);
    check("R1 reset dir read inst1", rd1, 16'hFFFF);
    check("R1 reset dir read inst0", rd0, 16'h0000);
    rstN = 1'b1;
    tick();

    // R9: synchronizer latency
    peek(2'd0);
    pinIn = 16'hA5C3;
    tick();
    check("R9 level after one edge inst1", rd1, 16'h0000);
    tick();
    check("R9 level after two edges inst1", rd1, 16'hA5C3);

    // R7/R8: bus bit 0 lands on pin 7 of inst0; inst1 ignores the address 0 write
    busWrite(2'd0, 16'h0001);
    check("R7/R8 mapped data write inst0", out0, 16'h0080);
    check("R5 data write ignored inst1", out1, 16'h0000);

    // R3: set of bus bit 8 raises pin 15 on inst0; inst1 loads full value
    busWrite(2'd1, 16'h0100);
    check("R3 set keeps others inst0", out0, 16'h8080);
    check("R5 set loads full inst1", out1, 16'h0100);
    peek(2'd1);
    check("R5 set readback inst1", rd1, 16'h0100);
    check("R11 set reads zero inst0", rd0, 16'h0000);

    // R4: clear bus bit 0 drops pin 7 on inst0; inst1 ignores it
    busWrite(2'd2, 16'h0001);
    check("R4 clear inst0", out0, 16'h8000);
    check("R5 clear ignored inst1", out1, 16'h0100);
    peek(2'd2);
    check("R5 unimplemented read inst1", rd1, 16'h0000);

    // R6: direction polarity
    busWrite(2'd3, 16'h00FF);
    check("R6 output polarity inst0", oe0, 16'h00FF);
    check("R6 input polarity inst1", oe1, 16'hFF00);

    // R10: inst0 pins 0..7 output (latch 0), pins 8..15 input (pinIn A5)
    peek(2'd0);
    check("R10 mixed level read inst0", rd0, 16'hA500);
    check("R10 option off reads pins inst1", rd1, 16'hA5C3);

    // Random phase, compared every cycle against the model
    for (int c = 0; c < 3000; c++) begin
      busWr = ($urandom_range(0, 3) != 0);
      busAddr = 2'($urandom_range(0, 3));
      busWrData = 16'($urandom);
      if ($urandom_range(0, 3) == 0) pinIn = 16'($urandom);
      tick();
    end
    busWr = 1'b0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule